// File: doc/BRIEF.md
# Tag Command Parser and Access Controller

This block sits behind the gap decoder of a passive read/write tag. It takes the reader's command one bit at a time, together with a strobe that marks the end of the command and a flag for timing errors seen while the bits arrived. It counts the bits itself. When the command ends, it works out what the tag does next: program a block, keep sending one block, restart, enter a test access, or go back to cyclic reading of a page.

The first two bits are the opcode. When password protection is on, a 32-bit password follows the opcode. It is checked bit by bit against the stored password word as each bit arrives, and a sticky mismatch flag replaces any copy of the received word. A command counts as valid only when its total bit count exactly matches one of the lengths allowed in the current mode. A separate wake-up rule controls whether the tag modulates at all while answer-on-request is enabled.

Top module: `tag_cmd_ctrl`

## Requirements
- R1: After reset `act_valid` is 0, `act` is NONE (0), `page` is 0, `blk_addr` is 0, and `mod_en` equals the inverse of `cfg_aor`.
- R2: A 2-bit command with opcode `1p` gives REG_READ (4) with `page`=p and `blk_addr`=1.
- R3: With password mode off, a 38-bit command `1p`, lock, 32 data bits (first received is bit 31), 3 address bits (MSB first) gives PROGRAM (1) with `wr_lock`, `wr_data`, `blk_addr` and `page` taken from those fields.
- R4: With password mode off, a 6-bit command `1p`, a 0 marker bit and 3 address bits gives BLOCK_READ (2) at that address and page. A 1 in the marker position gives REG_READ of block 1.
- R5: A 2-bit command `00` gives RESET (3) with `page`=0, and it clears any earlier wake-up.
- R6: A command with opcode `01` gives TEST (5) unless `cfg_master_key` is 6. In that case it gives NONE and leaves `page` unchanged.
- R7: With password mode on, the 32 bits after the opcode are compared with `pwd_word`, the first received bit against bit 31. On a match, a 70-bit command performs the write of R3 and a 38-bit command performs the direct access of R4.
- R8: With password mode on, a password mismatch never gives PROGRAM or BLOCK_READ. The result is REG_READ of block 1 of the page named in the opcode.
- R9: A bit count that fits no allowed length, or a raised `cmd_err`, gives REG_READ with `blk_addr`=1 and `page` taken from a `1p` opcode. If fewer than 2 bits arrived, `page` is left unchanged.
- R10: A valid write to a block whose bit in `lock_bits` is set, or any valid write while `cfg_otp` is set, gives BLOCK_READ at that address instead of PROGRAM.
- R11: With `cfg_aor` and password mode on, `mod_en` stays 0 until a 34-bit command made of opcode `10` and the matching password arrives. That command gives REG_READ and sets `mod_en`. A later command of an allowed length with a wrong password clears `mod_en`.
- R12: An end strobe with no bits received gives NONE and leaves `page` unchanged.
- R13: `act_valid` pulses for exactly the one cycle that follows each `cmd_end` strobe, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | One decoded command bit is present |
| bit_val | input | 1 | Value of that bit |
| cmd_end | input | 1 | Command finished (never in the same cycle as `bit_valid`) |
| cmd_err | input | 1 | A pulse-interval error was seen during this command |
| cfg_pwd_mode | input | 1 | Password protection enabled |
| cfg_aor | input | 1 | Answer-on-request enabled |
| cfg_otp | input | 1 | Every block treated as locked |
| cfg_master_key | input | 4 | Master key field; value 6 blocks test access |
| lock_bits | input | 8 | Lock flag for each block |
| pwd_word | input | 32 | Stored password |
| act_valid | output | 1 | Decision strobe |
| act | output | 3 | Action: 0 NONE, 1 PROGRAM, 2 BLOCK_READ, 3 RESET, 4 REG_READ, 5 TEST |
| page | output | 1 | Selected page |
| blk_addr | output | 3 | Block to program or send |
| wr_data | output | 32 | Data to program |
| wr_lock | output | 1 | New lock bit to program |
| mod_en | output | 1 | Modulation allowed |

## Verification
Every decision is registered once. The action, page, address, data and lock outputs change on the clock edge that samples `cmd_end`, and `act_valid` falls again one edge later. The bench drives each bit and the end strobe on falling edges. It reads the outputs on the falling edge right after the strobe is accepted, and again one cycle later to confirm that the strobe lasted exactly one cycle. `mod_en` depends on the registered wake-up state and on `cfg_aor`, so it is read in that same cycle. A password error injected at the last password bit checks that the mismatch flag, set when that bit arrives, is already in place at the decision edge.

// File: rtl/tag_cmd_pkg.sv
package tag_cmd_pkg;

  typedef enum logic [2:0] {
    ACT_NONE       = 3'd0,
    ACT_PROGRAM    = 3'd1,
    ACT_BLOCK_READ = 3'd2,
    ACT_RESET      = 3'd3,
    ACT_REG_READ   = 3'd4,
    ACT_TEST       = 3'd5
  } act_e;

  localparam int OPC_W = 2;

  // total bits of a write: opcode, optional password, lock, data, address
  function automatic int len_write(bit pwd, int pw_w, int data_w, int addr_w);
    return OPC_W + (pwd ? pw_w : 0) + 1 + data_w + addr_w;
  endfunction

  // total bits of a direct access: opcode, optional password, marker, address
  function automatic int len_direct(bit pwd, int pw_w, int addr_w);
    return OPC_W + (pwd ? pw_w : 0) + 1 + addr_w;
  endfunction

  // total bits of a wake-up: opcode and password
  function automatic int len_wake(int pw_w);
    return OPC_W + pw_w;
  endfunction

endpackage

// File: rtl/tag_bit_collect.sv
module tag_bit_collect #(
  parameter int PW_W  = 32,
  parameter int SH_W  = 36,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_val,
  input  logic             cmd_end,
  input  logic             pwd_mode,
  input  logic [PW_W-1:0]  pwd_word,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       op,
  output logic [SH_W-1:0]  shreg,
  output logic             pw_bad
);
  localparam int PSW = $clog2(PW_W);

  logic [PSW-1:0] pw_sel;
  logic           in_pw;

  always_comb begin
    int idx;
    idx    = PW_W + 1 - int'(cnt);   // bit index compared with the next arrival
    if (idx < 0) idx = 0;
    pw_sel = PSW'(idx);
    in_pw  = pwd_mode && (int'(cnt) >= 2) && (int'(cnt) < 2 + PW_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_end) begin
      cnt    <= '0;
      op     <= '0;
      shreg  <= '0;
      pw_bad <= 1'b0;
    end else if (bit_valid) begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(0)) op[1] <= bit_val;
      if (cnt == CNT_W'(1)) op[0] <= bit_val;
      shreg <= {shreg[SH_W-2:0], bit_val};
      if (in_pw && (bit_val != pwd_word[pw_sel])) pw_bad <= 1'b1;
    end
  end

  a_r7_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_bad && !cmd_end) |=> pw_bad);
  a_r13_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> (cnt == '0) && !pw_bad);

endmodule

// File: rtl/tag_cmd_decide.sv
module tag_cmd_decide
  import tag_cmd_pkg::*;
#(
  parameter int PW_W     = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 7,
  parameter int LOCK_KEY = 6,
  parameter int SH_W     = 1 + DATA_W + ADDR_W,
  parameter int NBLK     = 1 << ADDR_W
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        op,
  input  logic [SH_W-1:0]   shreg,
  input  logic              pw_bad,
  input  logic              cmd_err,
  input  logic              pwd_mode,
  input  logic              aor,
  input  logic              otp,
  input  logic [3:0]        master_key,
  input  logic [NBLK-1:0]   lock_bits,
  input  logic              cur_page,
  input  logic [ADDR_W-1:0] cur_addr,
  output act_e              d_act,
  output logic              d_page,
  output logic [ADDR_W-1:0] d_addr,
  output logic [DATA_W-1:0] d_data,
  output logic              d_lock,
  output logic              d_wake,
  output logic              d_sleep
);
  logic [ADDR_W-1:0] f_addr;
  logic              f_marker;
  int                n, lw, ld, lk;

  assign f_addr   = shreg[ADDR_W-1:0];
  assign f_marker = shreg[ADDR_W];
  assign d_data   = shreg[SH_W-2:ADDR_W];
  assign d_lock   = shreg[SH_W-1];

  always_comb begin
    n  = int'(cnt);
    lw = len_write(pwd_mode, PW_W, DATA_W, ADDR_W);
    ld = len_direct(pwd_mode, PW_W, ADDR_W);
    lk = len_wake(PW_W);
    d_act   = ACT_NONE;
    d_page  = cur_page;
    d_addr  = cur_addr;
    d_wake  = 1'b0;
    d_sleep = 1'b0;
    if (n == 0) begin
      d_act = ACT_NONE;
    end else if (cmd_err || n == 1) begin
      d_act  = ACT_REG_READ;
      d_addr = ADDR_W'(1);
      if (n >= 2 && op[1]) d_page = op[0];
    end else if (op == 2'b00) begin
      d_addr = ADDR_W'(1);
      d_act  = ACT_REG_READ;
      if (n == 2) begin
        d_act   = ACT_RESET;
        d_page  = 1'b0;
        d_addr  = cur_addr;
        d_sleep = 1'b1;
      end
    end else if (op == 2'b01) begin
      d_act = (int'(master_key) == LOCK_KEY) ? ACT_NONE : ACT_TEST;
    end else begin
      d_page = op[0];
      d_act  = ACT_REG_READ;
      d_addr = ADDR_W'(1);
      if (pwd_mode && pw_bad) begin
        if (n == lw || n == ld || n == lk) d_sleep = aor;
      end else if (n == lw) begin
        d_addr = f_addr;
        d_act  = (lock_bits[f_addr] || otp) ? ACT_BLOCK_READ : ACT_PROGRAM;
      end else if (n == ld && !f_marker) begin
        d_addr = f_addr;
        d_act  = ACT_BLOCK_READ;
      end else if (pwd_mode && aor && n == lk && !op[0]) begin
        d_wake = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tag_cmd_ctrl.sv
module tag_cmd_ctrl
  import tag_cmd_pkg::*;
#(
  parameter int PW_W     = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int LOCK_KEY = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic                 bit_val,
  input  logic                 cmd_end,
  input  logic                 cmd_err,
  input  logic                 cfg_pwd_mode,
  input  logic                 cfg_aor,
  input  logic                 cfg_otp,
  input  logic [3:0]           cfg_master_key,
  input  logic [(1<<ADDR_W)-1:0] lock_bits,
  input  logic [PW_W-1:0]      pwd_word,
  output logic                 act_valid,
  output logic [2:0]           act,
  output logic                 page,
  output logic [ADDR_W-1:0]    blk_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 wr_lock,
  output logic                 mod_en
);
  localparam int NBLK    = 1 << ADDR_W;
  localparam int SH_W    = 1 + DATA_W + ADDR_W;
  localparam int MAX_LEN = len_write(1'b1, PW_W, DATA_W, ADDR_W);
  localparam int CNT_W   = $clog2(MAX_LEN + 2);

  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        op;
  logic [SH_W-1:0]   shreg;
  logic              pw_bad;
  act_e              d_act;
  logic              d_page, d_lock, d_wake, d_sleep;
  logic [ADDR_W-1:0] d_addr;
  logic [DATA_W-1:0] d_data;
  logic              awake;

  tag_bit_collect #(.PW_W(PW_W), .SH_W(SH_W), .CNT_W(CNT_W)) collect_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
    .cmd_end(cmd_end), .pwd_mode(cfg_pwd_mode), .pwd_word(pwd_word),
    .cnt(bit_cnt), .op(op), .shreg(shreg), .pw_bad(pw_bad)
  );

  tag_cmd_decide #(.PW_W(PW_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
                   .LOCK_KEY(LOCK_KEY), .SH_W(SH_W), .NBLK(NBLK)) decide_i (
    .cnt(bit_cnt), .op(op), .shreg(shreg), .pw_bad(pw_bad), .cmd_err(cmd_err),
    .pwd_mode(cfg_pwd_mode), .aor(cfg_aor), .otp(cfg_otp), .master_key(cfg_master_key),
    .lock_bits(lock_bits), .cur_page(page), .cur_addr(blk_addr),
    .d_act(d_act), .d_page(d_page), .d_addr(d_addr), .d_data(d_data),
    .d_lock(d_lock), .d_wake(d_wake), .d_sleep(d_sleep)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act       <= ACT_NONE;
      page      <= 1'b0;
      blk_addr  <= '0;
      wr_data   <= '0;
      wr_lock   <= 1'b0;
      awake     <= 1'b0;
    end else begin
      act_valid <= cmd_end;
      if (cmd_end) begin
        act      <= d_act;
        page     <= d_page;
        blk_addr <= d_addr;
        wr_data  <= d_data;
        wr_lock  <= d_lock;
        if (d_wake)       awake <= 1'b1;
        else if (d_sleep) awake <= 1'b0;
      end
    end
  end

  assign mod_en = !cfg_aor || awake;

  a_r13_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> act_valid);
  a_r13_valid_only_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(cmd_end));
  a_r10_locked_not_programmed: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act == ACT_PROGRAM) |->
      (!$past(cfg_otp) && ((($past(lock_bits) >> blk_addr) & NBLK'(1)) == '0)));
  a_r8_bad_pw_not_programmed: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && (act == ACT_PROGRAM || act == ACT_BLOCK_READ) && $past(cfg_pwd_mode))
      |-> !$past(pw_bad));
  a_r11_wake_needs_aor: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake) |-> ($past(cfg_aor) && $past(cfg_pwd_mode) && !$past(pw_bad)));
  a_r12_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && bit_cnt == '0) |=> (act == ACT_NONE) && $stable(page));
  a_r6_test_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && !cmd_err && bit_cnt >= CNT_W'(2) && op == 2'b01 &&
     int'(cfg_master_key) == LOCK_KEY) |=> (act == ACT_NONE) && $stable(page));

endmodule

// File: tb/tag_cmd_ctrl_tb_top.sv
module tag_cmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0, bit_val = 1'b0, cmd_end = 1'b0, cmd_err = 1'b0;
  logic        cfg_pwd_mode = 1'b0, cfg_aor = 1'b0, cfg_otp = 1'b0;
  logic [3:0]  cfg_master_key = 4'd0;
  logic [7:0]  lock_bits = 8'h00;
  logic [31:0] pwd_word = 32'hDEAD_BEEF;
  logic        act_valid, page, wr_lock, mod_en;
  logic [2:0]  act, blk_addr;
  logic [31:0] wr_data;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tag_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
    .cmd_end(cmd_end), .cmd_err(cmd_err), .cfg_pwd_mode(cfg_pwd_mode),
    .cfg_aor(cfg_aor), .cfg_otp(cfg_otp), .cfg_master_key(cfg_master_key),
    .lock_bits(lock_bits), .pwd_word(pwd_word), .act_valid(act_valid), .act(act),
    .page(page), .blk_addr(blk_addr), .wr_data(wr_data), .wr_lock(wr_lock),
    .mod_en(mod_en)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // sends bits n-1 down to 0, then the end strobe; returns on the sample edge
  task automatic send(input logic [127:0] v, input int n, input logic err);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); bit_valid = 1'b1; bit_val = v[i];
    end
    @(negedge clk); bit_valid = 1'b0; cmd_end = 1'b1; cmd_err = err;
    @(negedge clk); cmd_end = 1'b0; cmd_err = 1'b0;
    chk("R13 strobe", act_valid, 1);
  endtask

  task automatic strobe_drop();
    @(negedge clk);
    chk("R13 strobe drop", act_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", act_valid, 0);
    chk("R1 act", act, 0);
    chk("R1 page", page, 0);
    chk("R1 addr", blk_addr, 0);
    chk("R1 mod_en", mod_en, 1);
  endtask

  task automatic t_page_read();
    send({126'd0, 2'b11}, 2, 0);
    chk("R2 act", act, 4); chk("R2 page", page, 1); chk("R2 addr", blk_addr, 1);
    strobe_drop();
  endtask

  task automatic t_std_write();
    send({90'd0, 2'b10, 1'b1, 32'hA5C3_1234, 3'd5}, 38, 0);
    chk("R3 act", act, 1); chk("R3 page", page, 0); chk("R3 addr", blk_addr, 5);
    chk("R3 data", wr_data, 32'hA5C3_1234); chk("R3 lock", wr_lock, 1);
    strobe_drop();
  endtask

  task automatic t_locked();
    lock_bits = 8'h20;
    send({90'd0, 2'b11, 1'b0, 32'h0000_0001, 3'd5}, 38, 0);
    chk("R10 lockbit act", act, 2); chk("R10 lockbit addr", blk_addr, 5);
    lock_bits = 8'h00; cfg_otp = 1'b1;
    send({90'd0, 2'b10, 1'b0, 32'h0000_0001, 3'd2}, 38, 0);
    chk("R10 otp act", act, 2); chk("R10 otp addr", blk_addr, 2);
    cfg_otp = 1'b0;
  endtask

  task automatic t_direct();
    send({122'd0, 2'b11, 1'b0, 3'd3}, 6, 0);
    chk("R4 act", act, 2); chk("R4 addr", blk_addr, 3); chk("R4 page", page, 1);
    send({122'd0, 2'b10, 1'b1, 3'd6}, 6, 0);
    chk("R4 marker act", act, 4); chk("R4 marker addr", blk_addr, 1);
    chk("R4 marker page", page, 0);
  endtask

  task automatic t_reset_cmd();
    send({126'd0, 2'b11}, 2, 0);
    send({126'd0, 2'b00}, 2, 0);
    chk("R5 act", act, 3); chk("R5 page", page, 0);
  endtask

  task automatic t_test();
    send({126'd0, 2'b11}, 2, 0);
    cfg_master_key = 4'd6;
    send({126'd0, 2'b01}, 2, 0);
    chk("R6 key6 act", act, 0); chk("R6 key6 page", page, 1);
    cfg_master_key = 4'd9;
    send({124'd0, 4'b0110}, 4, 0);
    chk("R6 key9 act", act, 5);
    cfg_master_key = 4'd0;
  endtask

  task automatic t_pwd();
    cfg_pwd_mode = 1'b1;
    send({58'd0, 2'b10, 32'hDEAD_BEEF, 1'b0, 32'h0BAD_F00D, 3'd4}, 70, 0);
    chk("R7 write act", act, 1); chk("R7 write data", wr_data, 32'h0BAD_F00D);
    chk("R7 write addr", blk_addr, 4); chk("R7 write lock", wr_lock, 0);
    send({90'd0, 2'b11, 32'hDEAD_BEEF, 1'b0, 3'd7}, 38, 0);
    chk("R7 direct act", act, 2); chk("R7 direct addr", blk_addr, 7);
    chk("R7 direct page", page, 1);
    send({58'd0, 2'b10, 32'hDEAD_BEEE, 1'b0, 32'h0BAD_F00D, 3'd4}, 70, 0);
    chk("R8 last bit act", act, 4); chk("R8 last bit addr", blk_addr, 1);
    chk("R8 last bit page", page, 0);
    send({90'd0, 2'b11, 32'h5EAD_BEEF, 1'b0, 3'd7}, 38, 0);
    chk("R8 first bit act", act, 4); chk("R8 first bit page", page, 1);
    cfg_pwd_mode = 1'b0;
  endtask

  task automatic t_errors();
    send({91'd0, 2'b11, 1'b0, 31'h1, 3'd5}, 37, 0);
    chk("R9 count act", act, 4); chk("R9 count page", page, 1); chk("R9 count addr", blk_addr, 1);
    send({122'd0, 2'b10, 1'b0, 3'd3}, 6, 1);
    chk("R9 err act", act, 4); chk("R9 err page", page, 0);
    send({127'd0, 1'b1}, 1, 0);
    chk("R9 short act", act, 4); chk("R9 short page", page, 0);
  endtask

  task automatic t_empty();
    send({126'd0, 2'b11}, 2, 0);
    send(128'd0, 0, 0);
    chk("R12 act", act, 0); chk("R12 page", page, 1);
  endtask

  task automatic t_aor();
    cfg_pwd_mode = 1'b1; cfg_aor = 1'b1;
    @(negedge clk);
    chk("R11 asleep", mod_en, 0);
    send({126'd0, 2'b10}, 2, 0);
    chk("R11 still asleep", mod_en, 0);
    send({94'd0, 2'b10, 32'hDEAD_BEEF}, 34, 0);
    chk("R11 wake act", act, 4); chk("R11 awake", mod_en, 1);
    send({90'd0, 2'b10, 32'h1234_5678, 1'b0, 3'd1}, 38, 0);
    chk("R11 deactivated", mod_en, 0);
    send({94'd0, 2'b10, 32'hDEAD_BEEF}, 34, 0);
    chk("R11 rewake", mod_en, 1);
    send({126'd0, 2'b00}, 2, 0);
    chk("R5 reset clears wake", mod_en, 0);
    cfg_pwd_mode = 1'b0; cfg_aor = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_read();
    t_std_write();
    t_locked();
    t_direct();
    t_reset_cmd();
    t_test();
    t_pwd();
    t_errors();
    t_empty();
    t_aor();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule